// File: doc/BRIEF.md
# Multiplexed 8-bit Management Bus Master

This block lets on-chip logic reach the registers of an external line-interface device over a narrow management bus. The bus has one 8-bit line set that carries the address first and the data after it. The block accepts one request at a time. A request carries an address, write data, a read/write flag and a one-of-two device select. The block then runs a complete bus cycle: an address-latch phase, a strobe phase and a hold phase. When the cycle ends it raises a one-cycle done pulse. On a read it also returns the captured byte.

Every minimum time on the bus is a parameter counted in cycles of the fast system clock. The default values fit a 12.5 ns period. The phases are built from these values:
- The latch phase is as long as the longest of three minimums: the latch-enable pulse width, the chip-select lead time and the address setup time.
- The strobe phase is stretched when needed, so that the whole chip-select window reaches its own minimum.

The block also carries two pins for the external device. Its reset request passes straight through. Its interrupt passes through a two-flop synchroniser.

Top module: `mbus_master`

## Requirements
- R1: While reset is held, and when it is released with no request, latch enable, both strobes, the AD output enable and done are low or inactive. All chip selects are high (inactive, active-low).
- R2: One cycle after an accepted request, latch enable goes high for 3 cycles with the defaults (the largest of the latch, chip-select-lead and address-setup minimums). During those cycles the AD output carries the request address with the output enable high.
- R3: For 1 cycle after latch enable falls, the address stays driven on AD with the output enable high, and both strobes stay inactive.
- R4: A bus cycle asserts exactly one active-low chip select, `bus_cs_n[req_sel]`, where select value 0 maps to bit 0. It stays constant for the whole cycle.
- R5: A write drives the write strobe low for 17 cycles with the defaults (15 minimum, stretched for the chip-select width), and the read strobe stays high. The write data is on AD, with the output enable high, from the first strobe cycle until the cycle after the chip select returns high.
- R6: A read drives the read strobe low for 17 cycles, and the output enable stays low from the strobe until the end of the cycle. The byte present on `bus_ad_in` in the last strobe cycle appears on `rsp_rdata`.
- R7: The chip select is low for 22 cycles (latch 3 + address hold 1 + strobe 17 + data hold 1). It rises 1 cycle after the strobe rises.
- R8: `rsp_done` is high for exactly one cycle, the cycle after the chip select rises. `rsp_rdata` changes only at the end of a read strobe, so a following write leaves it unchanged.
- R9: A request presented while a bus cycle is in progress is ignored. No second cycle starts, and the other chip select is never asserted.
- R10: `phy_int` copies `phy_int_in` two clock edges later (it is still low after the first edge). `phy_rst_out` follows `phy_rst_in` with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | start request, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | SEL_W (1) | index of the chip select to assert |
| req_addr | input | AD_W (8) | register address |
| req_wdata | input | AD_W (8) | write byte |
| rsp_rdata | output | AD_W (8) | last byte read |
| rsp_done | output | 1 | one-cycle end-of-cycle pulse |
| bus_ale | output | 1 | address latch enable, active high |
| bus_cs_n | output | N_CS (2) | chip selects, active low |
| bus_rd_n | output | 1 | read strobe, active low |
| bus_wr_n | output | 1 | write strobe, active low |
| bus_ad_out | output | AD_W (8) | AD value to drive |
| bus_ad_oe | output | 1 | AD pad output enable |
| bus_ad_in | input | AD_W (8) | AD value from the pad |
| phy_rst_in | input | 1 | reset request for the device |
| phy_rst_out | output | 1 | reset pin to the device |
| phy_int_in | input | 1 | asynchronous interrupt from the device |
| phy_int | output | 1 | synchronised interrupt level |

## Verification
The bench builds the block with its default values. These are an 8-bit AD bus, two chip selects, and the cycle counts for a 12.5 ns period. With those counts the chip-select minimum is longer than the sum of the phase minimums, so the strobe-stretch rule is exercised and the 17-cycle strobe can be checked exactly. Each transfer is compared against a cycle-by-cycle expected waveform built from the requirement figures. That comparison covers both chip selects, reads and writes, and a request injected mid-cycle.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE      = 3'd0,
      ST_ADDR_ALE  = 3'd1,
      ST_ADDR_HOLD = 3'd2,
      ST_STROBE    = 3'd3,
      ST_DATA_HOLD = 3'd4,
      ST_DONE      = 3'd5
   } mbus_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mbus_phase_ctl.sv
`timescale 1ns/1ps
module mbus_phase_ctl
   import mbus_pkg::*;
#(
   parameter int unsigned ALE_LEN = 3,
   parameter int unsigned AH_LEN  = 1,
   parameter int unsigned STB_LEN = 17,
   parameter int unsigned DH_LEN  = 1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   output mbus_state_e state_o,
   output logic        strobe_last_o
);

   localparam int unsigned MAX_LEN = max2(max2(ALE_LEN, AH_LEN), max2(STB_LEN, DH_LEN));
   localparam int unsigned CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

   mbus_state_e       state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              last;

   assign last          = (cnt_q == '0);
   assign state_o       = state_q;
   assign strobe_last_o = (state_q == ST_STROBE) && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_ADDR_ALE;
                  cnt_q   <= CNT_W'(ALE_LEN - 1);
               end
            end
            ST_ADDR_ALE: begin
               if (last) begin
                  state_q <= ST_ADDR_HOLD;
                  cnt_q   <= CNT_W'(AH_LEN - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_ADDR_HOLD: begin
               if (last) begin
                  state_q <= ST_STROBE;
                  cnt_q   <= CNT_W'(STB_LEN - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_STROBE: begin
               if (last) begin
                  state_q <= ST_DATA_HOLD;
                  cnt_q   <= CNT_W'(DH_LEN - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_DATA_HOLD: begin
               if (last) begin
                  state_q <= ST_DONE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_DONE: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/mbus_pin_drv.sv
`timescale 1ns/1ps
module mbus_pin_drv
   import mbus_pkg::*;
#(
   parameter int unsigned AD_W  = 8,
   parameter int unsigned N_CS  = 2,
   parameter int unsigned SEL_W = 1
) (
   input  mbus_state_e      state,
   input  logic             write,
   input  logic [SEL_W-1:0] sel,
   input  logic [AD_W-1:0]  addr,
   input  logic [AD_W-1:0]  wdata,
   output logic             ale,
   output logic [N_CS-1:0]  cs_n,
   output logic             rd_n,
   output logic             wr_n,
   output logic [AD_W-1:0]  ad_out,
   output logic             ad_oe,
   output logic             done
);

   logic addr_phase;
   logic cs_on;
   logic strobe_on;
   logic wdata_phase;

   always_comb begin
      addr_phase  = (state == ST_ADDR_ALE) || (state == ST_ADDR_HOLD);
      strobe_on   = (state == ST_STROBE);
      cs_on       = addr_phase || strobe_on || (state == ST_DATA_HOLD);
      wdata_phase = write && (strobe_on || (state == ST_DATA_HOLD) || (state == ST_DONE));
      ale         = (state == ST_ADDR_ALE);
      rd_n        = !(strobe_on && !write);
      wr_n        = !(strobe_on && write);
      ad_oe       = addr_phase || wdata_phase;
      ad_out      = addr_phase ? addr : wdata;
      done        = (state == ST_DONE);
   end

   for (genvar i = 0; i < N_CS; i++) begin : g_cs
      assign cs_n[i] = !(cs_on && (sel == SEL_W'(i)));
   end

endmodule

// File: rtl/mbus_sync.sv
`timescale 1ns/1ps
module mbus_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= d;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/mbus_master.sv
`timescale 1ns/1ps
module mbus_master
   import mbus_pkg::*;
#(
   parameter int unsigned AD_W           = 8,
   parameter int unsigned N_CS           = 2,
   parameter int unsigned T_ALE_CYC      = 2,
   parameter int unsigned T_CS_LEAD_CYC  = 2,
   parameter int unsigned T_AD_SU_CYC    = 3,
   parameter int unsigned T_AD_HOLD_CYC  = 1,
   parameter int unsigned T_STB_CYC      = 15,
   parameter int unsigned T_CS_WIDTH_CYC = 22,
   parameter int unsigned T_DAT_HOLD_CYC = 1,
   parameter int unsigned SYNC_STAGES    = 2,
   localparam int unsigned SEL_W         = (N_CS > 1) ? $clog2(N_CS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [SEL_W-1:0] req_sel,
   input  logic [AD_W-1:0]  req_addr,
   input  logic [AD_W-1:0]  req_wdata,
   output logic [AD_W-1:0]  rsp_rdata,
   output logic             rsp_done,
   output logic             bus_ale,
   output logic [N_CS-1:0]  bus_cs_n,
   output logic             bus_rd_n,
   output logic             bus_wr_n,
   output logic [AD_W-1:0]  bus_ad_out,
   output logic             bus_ad_oe,
   input  logic [AD_W-1:0]  bus_ad_in,
   input  logic             phy_rst_in,
   output logic             phy_rst_out,
   input  logic             phy_int_in,
   output logic             phy_int
);

   localparam int unsigned ALE_LEN   = max2(max2(T_ALE_CYC, T_CS_LEAD_CYC), T_AD_SU_CYC);
   localparam int unsigned AH_LEN    = max2(T_AD_HOLD_CYC, 1);
   localparam int unsigned DH_LEN    = max2(T_DAT_HOLD_CYC, 1);
   localparam int unsigned FIXED_LEN = ALE_LEN + AH_LEN + DH_LEN;
   localparam int unsigned CS_NEED   = (T_CS_WIDTH_CYC > FIXED_LEN) ? (T_CS_WIDTH_CYC - FIXED_LEN) : 1;
   localparam int unsigned STB_LEN   = max2(max2(T_STB_CYC, CS_NEED), 1);

   if (N_CS < 1) begin : g_bad_ncs
      $error("mbus_master: N_CS must be at least 1");
   end
   if (AD_W < 1) begin : g_bad_adw
      $error("mbus_master: AD_W must be at least 1");
   end
   if (ALE_LEN < 1) begin : g_bad_ale
      $error("mbus_master: latch phase must last at least one cycle");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("mbus_master: SYNC_STAGES must be at least 2");
   end

   mbus_state_e      state;
   logic             strobe_last;
   logic             accept;
   logic             write_q;
   logic [SEL_W-1:0] sel_q;
   logic [AD_W-1:0]  addr_q;
   logic [AD_W-1:0]  wdata_q;
   logic [AD_W-1:0]  rdata_q;

   assign accept = req_valid && (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         sel_q   <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         write_q <= req_write;
         sel_q   <= req_sel;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       rdata_q <= '0;
      else if (strobe_last && !write_q) rdata_q <= bus_ad_in;
   end

   assign rsp_rdata = rdata_q;

   mbus_phase_ctl #(
      .ALE_LEN (ALE_LEN),
      .AH_LEN  (AH_LEN),
      .STB_LEN (STB_LEN),
      .DH_LEN  (DH_LEN)
   ) u_phase (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (accept),
      .state_o       (state),
      .strobe_last_o (strobe_last)
   );

   mbus_pin_drv #(
      .AD_W  (AD_W),
      .N_CS  (N_CS),
      .SEL_W (SEL_W)
   ) u_pins (
      .state  (state),
      .write  (write_q),
      .sel    (sel_q),
      .addr   (addr_q),
      .wdata  (wdata_q),
      .ale    (bus_ale),
      .cs_n   (bus_cs_n),
      .rd_n   (bus_rd_n),
      .wr_n   (bus_wr_n),
      .ad_out (bus_ad_out),
      .ad_oe  (bus_ad_oe),
      .done   (rsp_done)
   );

   mbus_sync #(
      .STAGES (SYNC_STAGES)
   ) u_int_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (phy_int_in),
      .q     (phy_int)
   );

   assign phy_rst_out = phy_rst_in;

endmodule

// File: rtl/mbus_master_chk.sv
`timescale 1ns/1ps
module mbus_master_chk #(
   parameter int unsigned AD_W = 8,
   parameter int unsigned N_CS = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_ale,
   input logic [N_CS-1:0] bus_cs_n,
   input logic            bus_rd_n,
   input logic            bus_wr_n,
   input logic            bus_ad_oe,
   input logic            rsp_done,
   input logic [AD_W-1:0] rsp_rdata
);

   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~bus_cs_n) <= 1); // R4

   AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ((~bus_cs_n != '0) && ($past(~bus_cs_n) != '0)) |-> (bus_cs_n == $past(bus_cs_n))); // R4

   AST_ALE_HAS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |-> ((~bus_cs_n != '0) && bus_ad_oe)); // R2

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n)); // R5

   AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n || !bus_wr_n) |-> ((~bus_cs_n != '0) && !bus_ale)); // R7

   AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> bus_ad_oe); // R5

   AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_ad_oe); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done); // R8

   AST_DONE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> (~bus_cs_n == '0)); // R8

   AST_RDATA_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rsp_rdata) |-> !$past(bus_rd_n)); // R8

endmodule

bind mbus_master mbus_master_chk #(
   .AD_W (AD_W),
   .N_CS (N_CS)
) u_mbus_master_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_ale   (bus_ale),
   .bus_cs_n  (bus_cs_n),
   .bus_rd_n  (bus_rd_n),
   .bus_wr_n  (bus_wr_n),
   .bus_ad_oe (bus_ad_oe),
   .rsp_done  (rsp_done),
   .rsp_rdata (rsp_rdata)
);

// File: tb/test_mbus_master.sv
`timescale 1ns/1ps
module test_mbus_master;

   localparam int AD_W = 8;
   localparam int N_CS = 2;
   // expected phase lengths taken from the requirements
   localparam int E_ALE   = 3;
   localparam int E_AH    = 1;
   localparam int E_STB   = 17;
   localparam int E_DH    = 1;
   localparam int E_STB0  = E_ALE + E_AH;
   localparam int E_CS    = E_ALE + E_AH + E_STB + E_DH;
   localparam int E_DONE  = E_CS;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic            req_write = 1'b0;
   logic [0:0]      req_sel = '0;
   logic [AD_W-1:0] req_addr = '0;
   logic [AD_W-1:0] req_wdata = '0;
   logic [AD_W-1:0] rsp_rdata;
   logic            rsp_done;
   logic            bus_ale;
   logic [N_CS-1:0] bus_cs_n;
   logic            bus_rd_n;
   logic            bus_wr_n;
   logic [AD_W-1:0] bus_ad_out;
   logic            bus_ad_oe;
   logic [AD_W-1:0] bus_ad_in;
   logic            phy_rst_in = 1'b0;
   logic            phy_rst_out;
   logic            phy_int_in = 1'b0;
   logic            phy_int;
   logic [AD_W-1:0] rd_val = '0;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   // target model: valid byte only while the read strobe is low
   assign bus_ad_in = !bus_rd_n ? rd_val : ~rd_val;

   mbus_master i_mbus_master (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_write   (req_write),
      .req_sel     (req_sel),
      .req_addr    (req_addr),
      .req_wdata   (req_wdata),
      .rsp_rdata   (rsp_rdata),
      .rsp_done    (rsp_done),
      .bus_ale     (bus_ale),
      .bus_cs_n    (bus_cs_n),
      .bus_rd_n    (bus_rd_n),
      .bus_wr_n    (bus_wr_n),
      .bus_ad_out  (bus_ad_out),
      .bus_ad_oe   (bus_ad_oe),
      .bus_ad_in   (bus_ad_in),
      .phy_rst_in  (phy_rst_in),
      .phy_rst_out (phy_rst_out),
      .phy_int_in  (phy_int_in),
      .phy_int     (phy_int)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   // R1: reset values
   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(bus_ale == 1'b0 && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_done,
          "R1 strobes in reset", {bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done}, 5'b01100);
      chk(bus_cs_n == 2'b11, "R1 cs_n in reset", bus_cs_n, 2'b11);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(bus_ale == 1'b0 && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_done && bus_cs_n == 2'b11,
          "R1 idle after reset", {bus_ale, bus_cs_n, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_done},
          7'b0111100);
   endtask

   // one full bus cycle compared with the expected waveform
   task automatic t_xfer(input bit wr, input bit sel, input logic [AD_W-1:0] addr,
                         input logic [AD_W-1:0] wdata, input logic [AD_W-1:0] rdv,
                         input bit poke);
      logic [N_CS-1:0] e_cs_n;
      bit e_ale, e_cs, e_str, e_done, e_oe;
      @(negedge clk);
      req_write = wr;
      req_sel   = sel;
      req_addr  = addr;
      req_wdata = wdata;
      rd_val    = rdv;
      req_valid = 1'b1;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (poke && k == 6) begin
            // R9: request during the strobe, other select and data
            req_valid = 1'b1;
            req_sel   = ~sel;
            req_addr  = ~addr;
            req_write = ~wr;
         end
         e_ale  = (k < E_ALE);
         e_cs   = (k < E_CS);
         e_str  = (k >= E_STB0) && (k < E_STB0 + E_STB);
         e_done = (k == E_DONE);
         e_oe   = (k < E_STB0) || (wr && k >= E_STB0 && k <= E_DONE);
         e_cs_n = e_cs ? ~(2'b01 << sel) : 2'b11;
         chk(bus_ale == e_ale, "R2 latch enable", bus_ale, e_ale);
         chk(bus_cs_n == e_cs_n, poke ? "R9 R4 R7 chip select" : "R4 R7 chip select",
             bus_cs_n, e_cs_n);
         chk(bus_wr_n == !(e_str && wr), "R5 write strobe", bus_wr_n, !(e_str && wr));
         chk(bus_rd_n == !(e_str && !wr), "R6 read strobe", bus_rd_n, !(e_str && !wr));
         chk(bus_ad_oe == e_oe, "R3 R5 R6 output enable", bus_ad_oe, e_oe);
         if (e_oe) begin
            chk(bus_ad_out == ((k < E_STB0) ? addr : wdata), "R2 R3 R5 AD value",
                bus_ad_out, (k < E_STB0) ? addr : wdata);
         end
         chk(rsp_done == e_done, poke ? "R9 R8 done" : "R8 done", rsp_done, e_done);
      end
      req_valid = 1'b0;
      if (!wr) chk(rsp_rdata == rdv, "R6 read data", rsp_rdata, rdv);
   endtask

   // R8: read data held across a later write
   task automatic t_rdata_kept();
      t_xfer(1'b0, 1'b0, 8'h21, 8'h00, 8'h3C, 1'b0);
      t_xfer(1'b1, 1'b1, 8'h22, 8'hC7, 8'h99, 1'b0);
      chk(rsp_rdata == 8'h3C, "R8 read data kept", rsp_rdata, 8'h3C);
   endtask

   // R10: interrupt synchroniser and reset pass-through
   task automatic t_phy_pins();
      @(negedge clk);
      phy_int_in = 1'b1;
      @(negedge clk);
      chk(phy_int == 1'b0, "R10 interrupt after one edge", phy_int, 0);
      @(negedge clk);
      chk(phy_int == 1'b1, "R10 interrupt after two edges", phy_int, 1);
      phy_int_in = 1'b0;
      repeat (2) @(negedge clk);
      chk(phy_int == 1'b0, "R10 interrupt falls", phy_int, 0);
      phy_rst_in = 1'b1;
      #1;
      chk(phy_rst_out == 1'b1, "R10 reset pass high", phy_rst_out, 1);
      phy_rst_in = 1'b0;
      #1;
      chk(phy_rst_out == 1'b0, "R10 reset pass low", phy_rst_out, 0);
   endtask

   initial begin
      t_reset();
      t_xfer(1'b1, 1'b0, 8'h5A, 8'hA5, 8'h00, 1'b0);
      t_xfer(1'b1, 1'b1, 8'hFF, 8'h00, 8'h00, 1'b0);
      t_xfer(1'b0, 1'b1, 8'h00, 8'h00, 8'hE1, 1'b0);
      t_xfer(1'b0, 1'b0, 8'h81, 8'h00, 8'h18, 1'b0);
      t_rdata_kept();
      t_xfer(1'b1, 1'b0, 8'h13, 8'h6E, 8'h00, 1'b1);
      t_xfer(1'b0, 1'b1, 8'h44, 8'h00, 8'hB2, 1'b1);
      t_phy_pins();
      summary();
   end

endmodule